// File: doc/BRIEF.md
# Boundary-Scan Test Port with AC Pin Stimulus

This block is a compact test access port clocked by TCK. A tester steers it with TMS and TDI and reads TDO. It holds a 16-state controller, a 10-bit instruction register, a 32-bit identification register, a single-bit bypass register and a two-cell boundary chain. The chain drives one high-speed output pin and one ordinary output pin. Each pin has its own output enable.

Plain external test drives a static level onto both pins. Two further instructions drive the high-speed pin as an edge source for AC-coupled links. In pulse mode the pin produces a short burst of three transitions, keyed to entry into and exit from Run-Test/Idle. In train mode the pin keeps inverting on every falling TCK edge for as long as the controller dwells in Run-Test/Idle. The ordinary pin stays static in both modes.

The identification word is only meaningful once the device reports configuration status ready. A capture taken while that input is low yields all zeros, which a reader can tell apart from a real word because a real word always ends in 1.

Top module: `ac_bscan_tap`

## Requirements
- R1: The controller moves to Test-Logic-Reset when `trst_n` is sampled low on a rising TCK edge, or after five consecutive rising edges with TMS high from any state. In that state the instruction becomes IDCODE, both update cells clear to 0 and both pin enables go low.
- R2: The instruction register is 10 bits wide and is shifted in LSB first. On Capture-IR it loads 0000000001 (MSB on the left). The codes are: EXTEST = 0000001111, IDCODE = 0000000110, BYPASS = 1111111111, AC pulse = 0010001111, AC train = 0001001111. Any other code selects the bypass register.
- R3: Under IDCODE with `cfg_ready` high, Capture-DR loads the 32-bit word {version[3:0], part[15:0], maker[10:0], 1'b1}, which is shifted out LSB first. The defaults are version 0, part 16'h5A3C and maker 11'b00001101110.
- R4: Under IDCODE with `cfg_ready` low at Capture-DR, the captured word is all zeros.
- R5: Under BYPASS or an unlisted code, the data path is one bit long and captures 0. The output is TDI delayed by one shift.
- R6: TDO and `tdo_en` are updated on the falling TCK edge. `tdo_en` is high only during Shift-IR and Shift-DR.
- R7: The boundary chain is ordered TDI → high-speed cell (bit 1) → ordinary cell (bit 0) → TDO. Under EXTEST, Update-DR copies the chain to the pins on the falling edge and the pins then stay static. Both enables are high exactly under EXTEST, AC pulse and AC train.
- R8: In AC pulse mode the high-speed pin shows exactly three transitions for any dwell of N ≥ 1 falling edges in Run-Test/Idle. These are: the new value at Update-DR, the inverse on the first falling edge in Run-Test/Idle, and the true value on the first falling edge after leaving it.
- R9: In AC train mode the pin inverts on every falling edge in Run-Test/Idle. It returns to the true update value on leaving. For a preset opposite to the new value, this gives 1 + N + (N mod 2) transitions.
- R10: Under either AC instruction the ordinary pin behaves as under EXTEST. It changes only at Update-DR and then holds.
- R11: Capture-DR under a boundary instruction loads the current pin levels into the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on the rising TCK edge |
| tms | input | 1 | Mode select, sampled on the rising TCK edge |
| tdi | input | 1 | Serial data in |
| cfg_ready | input | 1 | Configuration status ready; high makes the identification word valid |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | TDO drive enable |
| pin_hs | output | 1 | High-speed (AC-capable) pin data |
| pin_hs_oe | output | 1 | High-speed pin enable |
| pin_std | output | 1 | Ordinary pin data |
| pin_std_oe | output | 1 | Ordinary pin enable |

## Verification
Two events can land on the same falling TCK edge of the high-speed pin: the Update-DR load of a new value, and the AC logic reacting to the next Run-Test/Idle entry. Likewise, the restore on leaving idle can meet the follow-on state. The bench provokes both by leaving Update-DR straight into Run-Test/Idle with dwells of one to six edges. It presets the pin to the opposite value, so every event produces a visible edge. It judges the result by counting pin transitions over the window against the arithmetic 3 or 1 + N + (N mod 2). It also confirms that the ordinary pin records exactly one transition over the same window.

// File: rtl/ac_bscan_pkg.sv
`timescale 1ns/1ps
package ac_bscan_pkg;

    localparam int IR_W    = 10;
    localparam int VER_W   = 4;
    localparam int PART_W  = 16;
    localparam int MFG_W   = 11;
    localparam int ID_W    = VER_W + PART_W + MFG_W + 1;
    localparam int BSR_W   = 2;
    localparam int HS_IDX  = 1;
    localparam int STD_IDX = 0;

    localparam logic [IR_W-1:0] OPC_EXTEST = 10'b0000001111;
    localparam logic [IR_W-1:0] OPC_IDCODE = 10'b0000000110;
    localparam logic [IR_W-1:0] OPC_BYPASS = '1;
    localparam logic [IR_W-1:0] OPC_PULSE  = 10'b0010001111;
    localparam logic [IR_W-1:0] OPC_TRAIN  = 10'b0001001111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 10'b0000000001;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [2:0] {
        OP_EXTEST, OP_IDCODE, OP_BYPASS, OP_PULSE, OP_TRAIN
    } instr_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic tms);
        tap_state_t n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic instr_t decode_ir(input logic [IR_W-1:0] code);
        instr_t i;
        if (code == OPC_EXTEST)      i = OP_EXTEST;
        else if (code == OPC_IDCODE) i = OP_IDCODE;
        else if (code == OPC_PULSE)  i = OP_PULSE;
        else if (code == OPC_TRAIN)  i = OP_TRAIN;
        else                         i = OP_BYPASS;
        return i;
    endfunction

    function automatic logic uses_chain(input instr_t i);
        return (i == OP_EXTEST) || (i == OP_PULSE) || (i == OP_TRAIN);
    endfunction

    function automatic logic is_ac(input instr_t i);
        return (i == OP_PULSE) || (i == OP_TRAIN);
    endfunction

    function automatic logic [ID_W-1:0] make_id(
        input logic [VER_W-1:0]  ver,
        input logic [PART_W-1:0] part,
        input logic [MFG_W-1:0]  mfg
    );
        return {ver, part, mfg, 1'b1};
    endfunction

endpackage

// File: rtl/ac_tap_fsm.sv
`timescale 1ns/1ps
module ac_tap_fsm
    import ac_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/ac_tap_ir.sv
`timescale 1ns/1ps
module ac_tap_ir
    import ac_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state,
    input  logic       tdi,
    output instr_t     instr,
    output logic       ir_tdo
);

    logic [IR_W-1:0] shift_q;
    logic [IR_W-1:0] hold_q;

    always_ff @(posedge tck) begin
        if (!trst_n)                 shift_q <= IR_CAPTURE;
        else if (state == ST_CAP_IR) shift_q <= IR_CAPTURE;
        else if (state == ST_SH_IR)  shift_q <= {tdi, shift_q[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) hold_q <= OPC_IDCODE;
        else if (state == ST_UPD_IR)      hold_q <= shift_q;
    end

    assign instr  = decode_ir(hold_q);
    assign ir_tdo = shift_q[0];

endmodule

// File: rtl/ac_tap_dr.sv
`timescale 1ns/1ps
module ac_tap_dr
    import ac_bscan_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_WORD = '0
)(
    input  logic             tck,
    input  logic             trst_n,
    input  tap_state_t       state,
    input  instr_t           instr,
    input  logic             tdi,
    input  logic             cfg_ready,
    input  logic             pin_hs,
    input  logic             pin_std,
    output logic             dr_tdo,
    output logic [BSR_W-1:0] upd,
    output logic             chain_load,
    output logic             hs_next
);

    logic [ID_W-1:0]  id_q;
    logic [BSR_W-1:0] chain_q;
    logic             byp_q;

    always_ff @(posedge tck) begin
        if (!trst_n) begin
            id_q    <= '0;
            chain_q <= '0;
            byp_q   <= 1'b0;
        end else if (state == ST_CAP_DR) begin
            id_q             <= cfg_ready ? ID_WORD : '0;
            chain_q[HS_IDX]  <= pin_hs;
            chain_q[STD_IDX] <= pin_std;
            byp_q            <= 1'b0;
        end else if (state == ST_SH_DR) begin
            case (instr)
                OP_IDCODE:                     id_q    <= {tdi, id_q[ID_W-1:1]};
                OP_EXTEST, OP_PULSE, OP_TRAIN: chain_q <= {tdi, chain_q[BSR_W-1:1]};
                default:                       byp_q   <= tdi;
            endcase
        end
    end

    assign chain_load = (state == ST_UPD_DR) && uses_chain(instr);
    assign hs_next    = chain_q[HS_IDX];

    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) upd <= '0;
        else if (chain_load)              upd <= chain_q;
    end

    always_comb begin
        case (instr)
            OP_IDCODE:                     dr_tdo = id_q[0];
            OP_EXTEST, OP_PULSE, OP_TRAIN: dr_tdo = chain_q[0];
            default:                       dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/ac_hs_driver.sv
`timescale 1ns/1ps
module ac_hs_driver
    import ac_bscan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_t state,
    input  instr_t     instr,
    input  logic       load,
    input  logic       load_val,
    input  logic       upd_val,
    output logic       hs
);

    logic was_idle;
    logic ac_mode;
    logic train;

    assign ac_mode = is_ac(instr);
    assign train   = (instr == OP_TRAIN);

    always_ff @(negedge tck) begin
        if (!trst_n || state == ST_RESET) begin
            hs       <= 1'b0;
            was_idle <= 1'b0;
        end else begin
            was_idle <= (state == ST_IDLE);
            if (load) begin
                hs <= load_val;
            end else if (state == ST_UPD_IR) begin
                hs <= upd_val;
            end else if (ac_mode && state == ST_IDLE) begin
                if (!was_idle)  hs <= ~upd_val;
                else if (train) hs <= ~hs;
            end else if (ac_mode && was_idle) begin
                hs <= upd_val;
            end
        end
    end

endmodule

// File: rtl/ac_bscan_tap.sv
`timescale 1ns/1ps
module ac_bscan_tap
    import ac_bscan_pkg::*;
#(
    parameter logic [VER_W-1:0]  VERSION  = '0,
    parameter logic [PART_W-1:0] PART_NUM = 16'h5A3C,
    parameter logic [MFG_W-1:0]  MFG_CODE = 11'b00001101110
)(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic cfg_ready,
    output logic tdo,
    output logic tdo_en,
    output logic pin_hs,
    output logic pin_hs_oe,
    output logic pin_std,
    output logic pin_std_oe
);

    localparam logic [ID_W-1:0] ID_WORD = make_id(VERSION, PART_NUM, MFG_CODE);

    tap_state_t       st;
    instr_t           ins;
    logic             ir_tdo;
    logic             dr_tdo;
    logic [BSR_W-1:0] upd;
    logic             chain_load;
    logic             hs_next;

    ac_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(st)
    );

    ac_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .state(st), .tdi(tdi),
        .instr(ins), .ir_tdo(ir_tdo)
    );

    ac_tap_dr #(.ID_WORD(ID_WORD)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(st), .instr(ins), .tdi(tdi),
        .cfg_ready(cfg_ready), .pin_hs(pin_hs), .pin_std(pin_std),
        .dr_tdo(dr_tdo), .upd(upd), .chain_load(chain_load), .hs_next(hs_next)
    );

    ac_hs_driver u_hs (
        .tck(tck), .trst_n(trst_n), .state(st), .instr(ins),
        .load(chain_load), .load_val(hs_next), .upd_val(upd[HS_IDX]), .hs(pin_hs)
    );

    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= (st == ST_SH_IR) || (st == ST_SH_DR);
            if (st == ST_SH_IR)      tdo <= ir_tdo;
            else if (st == ST_SH_DR) tdo <= dr_tdo;
            else                     tdo <= 1'b0;
        end
    end

    assign pin_std    = upd[STD_IDX];
    assign pin_hs_oe  = uses_chain(ins);
    assign pin_std_oe = uses_chain(ins);

endmodule

// File: rtl/ac_bscan_checker.sv
`timescale 1ns/1ps
module ac_bscan_checker
    import ac_bscan_pkg::*;
(
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input tap_state_t state,
    input instr_t     instr,
    input logic       tdo_en,
    input logic       pin_hs,
    input logic       pin_std
);

    a_r1_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == ST_RESET);

    a_r6_tdo_en_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

    a_r8_pulse_holds: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_PULSE && state == ST_IDLE && $past(state) == ST_IDLE)
        |-> pin_hs == $past(pin_hs));

    a_r9_train_toggles: assert property (@(posedge tck) disable iff (!trst_n)
        (instr == OP_TRAIN && state == ST_IDLE && $past(state) == ST_IDLE)
        |-> pin_hs != $past(pin_hs));

    a_r8_hs_change_window: assert property (@(posedge tck) disable iff (!trst_n)
        (pin_hs != $past(pin_hs))
        |-> (state == ST_UPD_DR || state == ST_UPD_IR || state == ST_IDLE ||
             state == ST_RESET || $past(state) == ST_IDLE));

    a_r10_std_static: assert property (@(posedge tck) disable iff (!trst_n)
        (pin_std != $past(pin_std)) |-> (state == ST_UPD_DR || state == ST_RESET));

endmodule

bind ac_bscan_tap ac_bscan_checker u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st), .instr(ins),
    .tdo_en(tdo_en), .pin_hs(pin_hs), .pin_std(pin_std)
);

// File: tb/ac_bscan_tap_test.sv
`timescale 1ns/1ps
module ac_bscan_tap_test;

    localparam logic [31:0] EXP_ID = {4'h0, 16'h5A3C, 11'b00001101110, 1'b1};
    localparam logic [9:0] C_EXTEST = 10'b0000001111;
    localparam logic [9:0] C_IDCODE = 10'b0000000110;
    localparam logic [9:0] C_BYPASS = 10'b1111111111;
    localparam logic [9:0] C_PULSE  = 10'b0010001111;
    localparam logic [9:0] C_TRAIN  = 10'b0001001111;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic cfg_ready = 1'b1;
    logic tdo, tdo_en, pin_hs, pin_hs_oe, pin_std, pin_std_oe;

    int nvec = 0;
    int nfail = 0;
    int hs_tr = 0;
    int std_tr = 0;
    logic hs_prev = 1'b0;
    logic std_prev = 1'b0;

    ac_bscan_tap uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .cfg_ready(cfg_ready),
        .tdo(tdo), .tdo_en(tdo_en), .pin_hs(pin_hs), .pin_hs_oe(pin_hs_oe),
        .pin_std(pin_std), .pin_std_oe(pin_std_oe)
    );

    always #2.5 tck = ~tck;

    always @(negedge tck) begin
        #1;
        if (pin_hs !== hs_prev)   hs_tr++;
        if (pin_std !== std_prev) std_tr++;
        hs_prev  = pin_hs;
        std_prev = pin_std;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic t, input logic d, output logic o, output logic e);
        @(negedge tck);
        #2;
        o = tdo;
        e = tdo_en;
        tms = t;
        tdi = d;
    endtask

    task automatic do_reset();
        logic o, e;
        trst_n = 1'b0;
        tms = 1'b1;
        repeat (3) cycle(1'b1, 1'b0, o, e);
        trst_n = 1'b1;
        cycle(1'b0, 1'b0, o, e);
    endtask

    task automatic shift_ir(input logic [9:0] code, input bit from_idle, input bit end_idle,
                            output logic [9:0] dout);
        logic o, e;
        dout = '0;
        if (from_idle) cycle(1'b1, 1'b0, o, e);
        cycle(1'b1, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        for (int i = 0; i < 10; i++) begin
            cycle(i == 9, code[i], o, e);
            dout[i] = o;
        end
        cycle(1'b1, 1'b0, o, e);
        cycle(end_idle ? 1'b0 : 1'b1, 1'b0, o, e);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, input bit from_idle,
                            input int idle_n, output logic [31:0] dout, output logic en_all);
        logic o, e;
        dout = '0;
        en_all = 1'b1;
        if (from_idle) cycle(1'b1, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        for (int i = 0; i < n; i++) begin
            cycle(i == n - 1, din[i], o, e);
            dout[i] = o;
            en_all = en_all & e;
        end
        cycle(1'b1, 1'b0, o, e);
        if (idle_n > 0) begin
            for (int i = 0; i < idle_n; i++) cycle(1'b0, 1'b0, o, e);
        end else begin
            cycle(1'b1, 1'b0, o, e);
        end
    endtask

    task automatic ac_window(input bit train, input logic v, input int n);
        logic [9:0] irq;
        logic [31:0] d;
        logic en, o, e;
        int exp_tr;
        do_reset();
        shift_ir(C_EXTEST, 1, 1, irq);
        shift_dr(2, {30'd0, ~v, ~v}, 1, 1, d, en);
        shift_ir(train ? C_TRAIN : C_PULSE, 1, 0, irq);
        hs_tr = 0;
        std_tr = 0;
        shift_dr(2, {30'd0, v, v}, 0, n, d, en);
        cycle(1'b1, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        exp_tr = train ? (1 + n + (n % 2)) : 3;
        if (train) begin
            chk($sformatf("R9 train transitions N=%0d v=%0d", n, v), hs_tr, exp_tr);
            chk("R9 train settles to true value", {31'd0, pin_hs}, {31'd0, v});
        end else begin
            chk($sformatf("R8 pulse transitions N=%0d v=%0d", n, v), hs_tr, exp_tr);
            chk("R8 pulse settles to true value", {31'd0, pin_hs}, {31'd0, v});
        end
        chk("R10 ordinary pin one transition", std_tr, 1);
        chk("R10 ordinary pin static value", {31'd0, pin_std}, {31'd0, v});
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        nfail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [9:0] irq;
        logic [31:0] d;
        logic en, o, e;

        do_reset();
        chk("R1 reset disables hs pin", {31'd0, pin_hs_oe}, 32'd0);
        chk("R1 reset disables std pin", {31'd0, pin_std_oe}, 32'd0);
        chk("R6 tdo_en low in idle", {31'd0, tdo_en}, 32'd0);

        shift_dr(32, 32'd0, 1, 1, d, en);
        chk("R1 R3 IDCODE after reset", d, EXP_ID);
        chk("R6 tdo_en high while shifting", {31'd0, en}, 32'd1);

        shift_ir(C_BYPASS, 1, 1, irq);
        chk("R2 IR capture pattern", {22'd0, irq}, 32'h001);
        shift_dr(8, 32'hB2, 1, 1, d, en);
        chk("R5 bypass one-shift delay", d & 32'hFF, 32'h64);

        shift_ir(10'h155, 1, 1, irq);
        shift_dr(8, 32'hB2, 1, 1, d, en);
        chk("R2 unlisted code selects bypass", d & 32'hFF, 32'h64);

        cfg_ready = 1'b0;
        shift_ir(C_IDCODE, 1, 1, irq);
        shift_dr(32, 32'd0, 1, 1, d, en);
        chk("R4 IDCODE with config not ready", d, 32'd0);
        cfg_ready = 1'b1;
        shift_dr(32, 32'd0, 1, 1, d, en);
        chk("R3 IDCODE with config ready", d, EXP_ID);

        shift_ir(C_EXTEST, 1, 1, irq);
        chk("R7 EXTEST enables hs pin", {31'd0, pin_hs_oe}, 32'd1);
        chk("R7 EXTEST enables std pin", {31'd0, pin_std_oe}, 32'd1);
        shift_dr(2, 32'b10, 1, 4, d, en);
        chk("R11 capture of reset pin levels", d & 32'h3, 32'b00);
        chk("R7 EXTEST hs pin value", {31'd0, pin_hs}, 32'd1);
        chk("R7 EXTEST std pin value", {31'd0, pin_std}, 32'd0);
        hs_tr = 0;
        repeat (4) cycle(1'b0, 1'b0, o, e);
        chk("R7 EXTEST hs pin static in idle", hs_tr, 0);
        shift_dr(2, 32'b01, 1, 1, d, en);
        chk("R11 capture of driven pin levels", d & 32'h3, 32'b10);
        chk("R7 EXTEST chain order", {30'd0, pin_hs, pin_std}, 32'b01);

        cycle(1'b1, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        repeat (5) cycle(1'b1, 1'b0, o, e);
        cycle(1'b0, 1'b0, o, e);
        chk("R1 five TMS high disables pins", {31'd0, pin_hs_oe}, 32'd0);
        chk("R1 five TMS high clears std cell", {31'd0, pin_std}, 32'd0);
        shift_dr(32, 32'd0, 1, 1, d, en);
        chk("R1 five TMS high restores IDCODE", d, EXP_ID);

        for (int v = 0; v < 2; v++) begin
            for (int n = 1; n <= 4; n++) ac_window(1'b0, v[0], n);
            for (int n = 1; n <= 6; n++) ac_window(1'b1, v[0], n);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule